// File: doc/BRIEF.md
# Three-Wire Configuration Loader

This block is a serial slave that takes configuration words from a host microcontroller over three lines: a shift clock, a data line and an enable line. It samples all three lines with the local system clock. On each rising edge of the host shift clock it shifts in one data bit, most significant bit first. Each level of the enable line forms one frame. The frame ends when enable toggles, and at that point the collected word is either written to its destination register or discarded.

While enable is low, a frame must hold exactly 16 bits. Its two leading bits act as a mode field that picks one of four destinations: the control word, the receive divider, the reference divider with its two-bit rate selection, or the transmit divider. While enable is high, the frame goes to a fifth register that holds a 4-bit low-battery code and a 6-bit oscillator capacitor selection. That frame may be 12 or 16 bits long and must start with a set marker bit. Its payload is always its last ten bits. The low-battery code is also decoded into a threshold in millivolts for the supply monitor.

Top module: `tw_prog_if`

## Requirements
- R1: After reset, the receive divider reads 7215, the transmit divider 9966, the reference divider 2048, and the reference rate select reads 0. All control outputs, the low-battery code and the capacitor selection read 0.
- R2: Data is taken MSB first. An enable-low frame of exactly 16 bits with mode bits [15:14] = 00 loads the control outputs from these word bits: [13] TX loop power-off, [11] compressor mute, [10] compressor power-save, [9] expander mute, [8] expander power-save, [7] lock/carrier output select, [6] low-battery monitor power-off, [5] RX power-off, and [4:3] as the test pair {bit4, bit3}. Bits 12, 2, 1 and 0 have no effect.
- R3: An enable-low 16-bit frame with mode 01 loads the receive divider from bits [13:0] and changes no other register.
- R4: An enable-low 16-bit frame with mode 10 loads the reference divider from bits [11:0] and the reference rate select from bits [13:12].
- R5: An enable-low 16-bit frame with mode 11 loads the transmit divider from bits [13:0].
- R6: An enable-high 16-bit frame with bit 15 set loads the low-battery code from bits [9:6] and the capacitor selection from bits [5:0]. Bits [14:10] have no effect.
- R7: An enable-high 12-bit frame with bit 11 set loads the low-battery code from bits [9:6] and the capacitor selection from bits [5:0]. Bit 10 has no effect.
- R8: An enable-high frame of a valid length whose leading bit (bit 15 for 16 bits, bit 11 for 12 bits) is clear leaves every register unchanged.
- R9: An enable-low frame of any length other than 16, or an enable-high frame of any length other than 12 or 16, leaves every register unchanged.
- R10: The threshold output reads 3450 for code 0000, 3300 for 1011, 3000 for 1101, 2200 for 0111 and 2100 for 1111, with the code written as bits [3:0]. Any other code reads 0.
- R11: Registers change only at a frame end. A toggle of the enable line shows at the outputs on the third rising system clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clk | input | 1 | Host shift clock (asynchronous) |
| host_dat | input | 1 | Host serial data |
| host_en | input | 1 | Host enable; its level selects the frame type |
| ctl_tx_pll_off | output | 1 | TX loop power-off |
| ctl_cmp_mute | output | 1 | Compressor mute |
| ctl_cmp_save | output | 1 | Compressor power-save |
| ctl_exp_mute | output | 1 | Expander mute |
| ctl_exp_save | output | 1 | Expander power-save |
| ctl_lock_sel | output | 1 | Lock-detect versus carrier-detect output select |
| ctl_lowbat_off | output | 1 | Low-battery monitor power-off |
| ctl_rx_off | output | 1 | Receiver power-off |
| ctl_test | output | 2 | Test mode pair |
| rx_div | output | 14 | Receive channel divider |
| tx_div | output | 14 | Transmit channel divider |
| ref_div | output | 12 | Reference divider |
| ref_sel | output | 2 | Reference rate selection |
| lowbat_code | output | 4 | Low-battery threshold code |
| osc_cap | output | 6 | Oscillator capacitor selection |
| lowbat_mv | output | 12 | Decoded threshold in millivolts, 0 if the code is unlisted |

## Verification
Each host line passes through two synchronizer flops and one edge register. A host clock rise therefore reaches the shift register on the third system clock edge, and an enable toggle updates the outputs on the third edge as well. The bench holds each host level for four system cycles and samples at falling edges. At a frame end it checks for the old value two falling edges after the toggle and for the new value at the third. Every other frame is checked against the bench model eight cycles after the toggle, well after the update has settled.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int WORD_W  = 16;
  localparam int SHORT_W = 12;
  localparam int DIV_W   = 14;
  localparam int REF_W   = 12;
  localparam int LBD_W   = 4;
  localparam int CAP_W   = 6;
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CTL_W   = 10;
  localparam int MV_W    = 12;

  localparam logic [DIV_W-1:0] RX_RST  = 14'd7215;
  localparam logic [DIV_W-1:0] TX_RST  = 14'd9966;
  localparam logic [REF_W-1:0] REF_RST = 12'd2048;

  typedef enum logic [1:0] {
    DST_CTL = 2'b00,
    DST_RX  = 2'b01,
    DST_REF = 2'b10,
    DST_TX  = 2'b11
  } dst_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/tw_shift.sv
module tw_shift
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_lvl,
  input  logic              sdat_lvl,
  input  logic              en_lvl,
  output logic              commit,
  output logic              frm_lvl,
  output logic [CNT_W-1:0]  frm_cnt,
  output logic [WORD_W-1:0] frm_word
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W + 1);

  logic              sclk_q, en_q, bit_stb;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;

  assign bit_stb = sclk_lvl & ~sclk_q;
  assign commit  = en_lvl ^ en_q;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (commit) begin
      cnt_d = '0;
    end else if (bit_stb) begin
      sh_d  = {sh_q[WORD_W-2:0], sdat_lvl};
      cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      sclk_q <= sclk_lvl;
      en_q   <= en_lvl;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
    end
  end

  assign frm_lvl  = en_q;
  assign frm_cnt  = cnt_q;
  assign frm_word = sh_q;
endmodule

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              frm_lvl,
  input  logic [CNT_W-1:0]  frm_cnt,
  input  logic [WORD_W-1:0] frm_word,
  output logic [CTL_W-1:0]  ctl,
  output logic [DIV_W-1:0]  rx_div,
  output logic [DIV_W-1:0]  tx_div,
  output logic [REF_W-1:0]  ref_div,
  output logic [1:0]        ref_sel,
  output logic [LBD_W-1:0]  lbd,
  output logic [CAP_W-1:0]  cap,
  output logic [MV_W-1:0]   mv
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [DIV_W-1:0] rx_q, rx_d, tx_q, tx_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [1:0]       sel_q, sel_d;
  logic [LBD_W-1:0] lbd_q, lbd_d;
  logic [CAP_W-1:0] cap_q, cap_d;
  logic             low_ok, high_ok;
  dst_e             dst;

  assign dst     = dst_e'(frm_word[WORD_W-1 -: 2]);
  assign low_ok  = commit & ~frm_lvl & (frm_cnt == CNT_W'(WORD_W));
  assign high_ok = commit & frm_lvl &
                   (((frm_cnt == CNT_W'(WORD_W))  & frm_word[WORD_W-1]) |
                    ((frm_cnt == CNT_W'(SHORT_W)) & frm_word[SHORT_W-1]));

  always_comb begin
    ctl_d = ctl_q;
    rx_d  = rx_q;
    tx_d  = tx_q;
    ref_d = ref_q;
    sel_d = sel_q;
    lbd_d = lbd_q;
    cap_d = cap_q;
    if (low_ok) begin
      unique case (dst)
        DST_CTL: ctl_d = {frm_word[13], frm_word[11:3]};
        DST_RX:  rx_d  = frm_word[DIV_W-1:0];
        DST_REF: begin
          ref_d = frm_word[REF_W-1:0];
          sel_d = frm_word[13:12];
        end
        DST_TX:  tx_d  = frm_word[DIV_W-1:0];
      endcase
    end
    if (high_ok) begin
      lbd_d = frm_word[CAP_W +: LBD_W];
      cap_d = frm_word[CAP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rx_q  <= RX_RST;
      tx_q  <= TX_RST;
      ref_q <= REF_RST;
      sel_q <= '0;
      lbd_q <= '0;
      cap_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      ref_q <= ref_d;
      sel_q <= sel_d;
      lbd_q <= lbd_d;
      cap_q <= cap_d;
    end
  end

  always_comb begin
    unique case (lbd_q)
      4'b0000: mv = MV_W'(3450);
      4'b1011: mv = MV_W'(3300);
      4'b1101: mv = MV_W'(3000);
      4'b0111: mv = MV_W'(2200);
      4'b1111: mv = MV_W'(2100);
      default: mv = '0;
    endcase
  end

  assign ctl     = ctl_q;
  assign rx_div  = rx_q;
  assign tx_div  = tx_q;
  assign ref_div = ref_q;
  assign ref_sel = sel_q;
  assign lbd     = lbd_q;
  assign cap     = cap_q;
endmodule

// File: rtl/tw_prog_if.sv
module tw_prog_if
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_clk,
  input  logic             host_dat,
  input  logic             host_en,
  output logic             ctl_tx_pll_off,
  output logic             ctl_cmp_mute,
  output logic             ctl_cmp_save,
  output logic             ctl_exp_mute,
  output logic             ctl_exp_save,
  output logic             ctl_lock_sel,
  output logic             ctl_lowbat_off,
  output logic             ctl_rx_off,
  output logic [1:0]       ctl_test,
  output logic [DIV_W-1:0] rx_div,
  output logic [DIV_W-1:0] tx_div,
  output logic [REF_W-1:0] ref_div,
  output logic [1:0]       ref_sel,
  output logic [LBD_W-1:0] lowbat_code,
  output logic [CAP_W-1:0] osc_cap,
  output logic [MV_W-1:0]  lowbat_mv
);
  logic [1:0]        rst_pipe;
  logic              rst_q;
  logic [2:0]        line_s;
  logic              frm_commit, frm_lvl;
  logic [CNT_W-1:0]  frm_cnt;
  logic [WORD_W-1:0] frm_word;
  logic [CTL_W-1:0]  ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  tw_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_q),
    .d     ({host_en, host_dat, host_clk}),
    .q     (line_s)
  );

  tw_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .sclk_lvl (line_s[0]),
    .sdat_lvl (line_s[1]),
    .en_lvl   (line_s[2]),
    .commit   (frm_commit),
    .frm_lvl  (frm_lvl),
    .frm_cnt  (frm_cnt),
    .frm_word (frm_word)
  );

  tw_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_q),
    .commit   (frm_commit),
    .frm_lvl  (frm_lvl),
    .frm_cnt  (frm_cnt),
    .frm_word (frm_word),
    .ctl      (ctl),
    .rx_div   (rx_div),
    .tx_div   (tx_div),
    .ref_div  (ref_div),
    .ref_sel  (ref_sel),
    .lbd      (lowbat_code),
    .cap      (osc_cap),
    .mv       (lowbat_mv)
  );

  assign {ctl_tx_pll_off, ctl_cmp_mute, ctl_cmp_save, ctl_exp_mute,
          ctl_exp_save, ctl_lock_sel, ctl_lowbat_off, ctl_rx_off,
          ctl_test} = ctl;
endmodule

// File: rtl/tw_prog_if_chk.sv
module tw_prog_if_chk
  import tw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              frm_lvl,
  input logic [CNT_W-1:0]  frm_cnt,
  input logic [WORD_W-1:0] frm_word,
  input logic [CTL_W-1:0]  ctl,
  input logic [DIV_W-1:0]  rx_div,
  input logic [DIV_W-1:0]  tx_div,
  input logic [REF_W-1:0]  ref_div,
  input logic [1:0]        ref_sel,
  input logic [LBD_W-1:0]  lbd,
  input logic [CAP_W-1:0]  cap,
  input logic [MV_W-1:0]   mv
);
  // R3
  rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frm_lvl && frm_cnt == CNT_W'(16) && frm_word[15:14] == 2'b01)
    |=> rx_div == $past(frm_word[13:0]));

  // R5
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frm_lvl && frm_cnt == CNT_W'(16) && frm_word[15:14] == 2'b11)
    |=> tx_div == $past(frm_word[13:0]));

  // R9
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !frm_lvl && frm_cnt != CNT_W'(16))
    |=> $stable(ctl) && $stable(rx_div) && $stable(tx_div) &&
        $stable(ref_div) && $stable(ref_sel));

  // R8
  no_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && frm_lvl && frm_cnt == CNT_W'(16) && !frm_word[15])
    |=> $stable(lbd) && $stable(cap));

  // R11
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctl) && $stable(rx_div) && $stable(tx_div) &&
                $stable(ref_div) && $stable(lbd) && $stable(cap));

  // R10
  mv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv == 12'd0 || mv == 12'd3450 || mv == 12'd3300 ||
    mv == 12'd3000 || mv == 12'd2200 || mv == 12'd2100);
endmodule

bind tw_prog_if tw_prog_if_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .commit   (frm_commit),
  .frm_lvl  (frm_lvl),
  .frm_cnt  (frm_cnt),
  .frm_word (frm_word),
  .ctl      (ctl),
  .rx_div   (rx_div),
  .tx_div   (tx_div),
  .ref_div  (ref_div),
  .ref_sel  (ref_sel),
  .lbd      (lowbat_code),
  .cap      (osc_cap),
  .mv       (lowbat_mv)
);

// File: tb/tw_prog_if_bench.sv
module tw_prog_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_clk = 1'b0, host_dat = 1'b0, host_en = 1'b0;
  logic        o_txoff, o_cmute, o_csave, o_emute, o_esave, o_lsel, o_lboff, o_rxoff;
  logic [1:0]  o_test, o_rsel;
  logic [13:0] o_rx, o_tx;
  logic [11:0] o_ref, o_mv;
  logic [3:0]  o_lbd;
  logic [5:0]  o_cap;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [9:0]  m_ctl;
  logic [13:0] m_rx, m_tx;
  logic [11:0] m_ref;
  logic [1:0]  m_sel;
  logic [3:0]  m_lbd;
  logic [5:0]  m_cap;

  always #2.5 clk = ~clk;

  tw_prog_if u_tw_prog_if (
    .clk(clk), .rst_n(rst_n), .host_clk(host_clk), .host_dat(host_dat),
    .host_en(host_en), .ctl_tx_pll_off(o_txoff), .ctl_cmp_mute(o_cmute),
    .ctl_cmp_save(o_csave), .ctl_exp_mute(o_emute), .ctl_exp_save(o_esave),
    .ctl_lock_sel(o_lsel), .ctl_lowbat_off(o_lboff), .ctl_rx_off(o_rxoff),
    .ctl_test(o_test), .rx_div(o_rx), .tx_div(o_tx), .ref_div(o_ref),
    .ref_sel(o_rsel), .lowbat_code(o_lbd), .osc_cap(o_cap), .lowbat_mv(o_mv)
  );

  function automatic int mv_of(logic [3:0] c);
    case (c)
      4'b0000: return 3450;
      4'b1011: return 3300;
      4'b1101: return 3000;
      4'b0111: return 2200;
      4'b1111: return 2100;
      default: return 0;
    endcase
  endfunction

  function automatic void model_frame(bit lvl, int n, logic [31:0] w);
    if (!lvl && n == 16) begin
      case (w[15:14])
        2'b00: m_ctl = {w[13], w[11:3]};
        2'b01: m_rx  = w[13:0];
        2'b10: begin m_ref = w[11:0]; m_sel = w[13:12]; end
        default: m_tx = w[13:0];
      endcase
    end else if (lvl && ((n == 16 && w[15]) || (n == 12 && w[11]))) begin
      m_lbd = w[9:6];
      m_cap = w[5:0];
    end
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "ctl", int'({o_txoff, o_cmute, o_csave, o_emute, o_esave,
                          o_lsel, o_lboff, o_rxoff, o_test}), int'(m_ctl));
    chk(tag, "rx_div", int'(o_rx), int'(m_rx));
    chk(tag, "tx_div", int'(o_tx), int'(m_tx));
    chk(tag, "ref_div", int'(o_ref), int'(m_ref));
    chk(tag, "ref_sel", int'(o_rsel), int'(m_sel));
    chk(tag, "lbd", int'(o_lbd), int'(m_lbd));
    chk(tag, "cap", int'(o_cap), int'(m_cap));
    chk(tag, "mv", int'(o_mv), mv_of(m_lbd));
  endtask

  task automatic shift_bits(int n, logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      host_dat = w[i];
      repeat (4) @(negedge clk);
      host_clk = 1'b1;
      repeat (4) @(negedge clk);
      host_clk = 1'b0;
    end
  endtask

  task automatic open_level(bit lvl);
    if (host_en != lvl) begin
      host_en = lvl;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic send(string tag, bit lvl, int n, logic [31:0] w);
    open_level(lvl);
    shift_bits(n, w);
    repeat (2) @(negedge clk);
    host_en = ~lvl;
    repeat (8) @(negedge clk);
    model_frame(lvl, n, w);
    check_all(tag);
  endtask

  initial begin
    m_ctl = '0; m_rx = 14'd7215; m_tx = 14'd9966; m_ref = 12'd2048;
    m_sel = '0; m_lbd = '0; m_cap = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R1");

    // R2: every control bit set, ignored bits 12 and 2..0 also set
    send("R2", 1'b0, 16, 32'h3FFF);
    // R2: ignored bits only
    send("R2", 1'b0, 16, 32'h1007);
    // R2: MSB-first ordering check with an asymmetric pattern
    send("R2", 1'b0, 16, 32'h2A50);
    send("R3", 1'b0, 16, 32'h4000 | 32'd123);
    send("R4", 1'b0, 16, 32'h8000 | 32'h2ABC);
    send("R5", 1'b0, 16, 32'hC000 | 32'd16383);
    send("R6", 1'b1, 16, 32'h8000 | 32'h7C00 | {22'd0, 4'b1011, 6'b100101});
    send("R7", 1'b1, 12, 32'h800 | 32'h400 | {22'd0, 4'b0111, 6'b011010});
    send("R8", 1'b1, 16, 32'h0000 | {22'd0, 4'b1111, 6'b111111});
    send("R8", 1'b1, 12, 32'h000 | {22'd0, 4'b1101, 6'b000001});
    send("R9", 1'b0, 15, 32'h4001);
    send("R9", 1'b0, 17, 32'h1_4002);
    send("R9", 1'b1, 14, 32'h3FFF);
    send("R9", 1'b0, 12, 32'hFFF);

    foreach (m_lbd[i]) begin end
    send("R10", 1'b1, 12, 32'h800 | {22'd0, 4'b0000, 6'd3});
    send("R10", 1'b1, 12, 32'h800 | {22'd0, 4'b1011, 6'd3});
    send("R10", 1'b1, 12, 32'h800 | {22'd0, 4'b1101, 6'd3});
    send("R10", 1'b1, 16, 32'h8000 | {22'd0, 4'b0111, 6'd3});
    send("R10", 1'b1, 16, 32'h8000 | {22'd0, 4'b1111, 6'd3});
    send("R10", 1'b1, 16, 32'h8000 | {22'd0, 4'b0001, 6'd3});

    // R11: update lands on the third edge after the enable toggle
    open_level(1'b0);
    shift_bits(16, 32'h4000 | 32'd4242);
    repeat (4) @(negedge clk);
    check_all("R11");
    host_en = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R11");
    @(negedge clk);
    model_frame(1'b0, 16, 32'h4000 | 32'd4242);
    check_all("R11");
    repeat (8) @(negedge clk);

    // random mix: R3 R6 R9
    begin
      void'($urandom(32'd1234));
      for (int k = 0; k < 80; k++) begin
        bit          lvl;
        int          n, sel;
        logic [31:0] w;
        lvl = 1'($urandom());
        sel = int'($urandom_range(0, 5));
        n = (sel < 3) ? 16 : (sel < 5) ? 12 : int'($urandom_range(1, 19));
        w = $urandom();
        send(lvl ? "R6" : "R3", lvl, n, w);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule